// File: doc/BRIEF.md
# Multicycle Processor Step Controller

This block sequences a 32-bit multicycle processor. The processor has one memory for instructions and data and a single ALU that is shared between steps. The controller is a Moore state machine. Each cycle it selects which datapath registers capture a value and how the shared muxes are steered. Every instruction starts with two common steps. In the first, the instruction is fetched and the ALU computes PC+4. In the second, the source registers are read and the ALU speculatively forms the branch target. The instruction class then picks a short chain of further steps, after which the machine returns to fetch.

The block observes three things: the opcode held in the instruction register, the function field of register-format instructions, and the zero and overflow flags of the ALU. Two exception steps save the faulting PC, minus 4, to an exception-PC register, record a cause bit and steer the PC to a fixed vector. One handles a trapping overflow and the other an undefined opcode. A dedicated link step serves jump-and-link.

Top module: `mcc_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low at a clock edge, the state returns to fetch, and every output is 0 for as long as `rst_n` stays low. The first cycle after release is a fetch step.
- R2: Fetch step: `pc_we`, `ir_we` and `mem_rd` are 1, `addr_sel`=0 (PC), `alu_a_sel`=0 (PC), `alu_b_sel`=01 (constant 4), `alu_op`=00 (add) and `pc_src`=00 (ALU result).
- R3: Decode step: `ab_we` and `aluout_we` are 1, `alu_a_sel`=0, `alu_b_sel`=11 (sign-extended immediate shifted left by 2) and `alu_op`=00.
- R4: Load (opcode 100011) runs in 5 cycles. Step 3 is an address step with `aluout_we`, `alu_a_sel`=1 (A), `alu_b_sel`=10 (sign-extended immediate) and add. Step 4 has `mdr_we`, `mem_rd` and `addr_sel`=1 (ALU-out). Step 5 has `rf_we`, `reg_dst`=00 (bits 20..16) and `wb_src`=01 (memory data).
- R5: Store (opcode 101011) runs in 4 cycles. It uses the same address step as a load, then one cycle with `mem_we` and `addr_sel`=1.
- R6: Register-format (opcode 000000) runs in 4 cycles. Step 3 has `aluout_we`, `alu_a_sel`=1, `alu_b_sel`=00 (B) and `alu_op`=10 (function field). Step 4 has `rf_we`, `reg_dst`=01 (bits 15..11) and `wb_src`=00 (ALU-out).
- R7: Any opcode with top bits 001 is an immediate instruction and runs in 4 cycles. Step 3 has `aluout_we`, `alu_a_sel`=1, `alu_b_sel`=10 and `alu_op`=11 (opcode-selected). Step 4 has `rf_we`, `reg_dst`=00 and `wb_src`=00.
- R8: Branch (opcode 000100) runs in 3 cycles. Step 3 has `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01 (subtract) and `pc_src`=01 (ALU-out), and `pc_we` equals `alu_zero`.
- R9: Jump (opcode 000010) runs in 3 cycles. Step 3 has `pc_we` with `pc_src`=10 (jump target).
- R10: Jump-and-link (opcode 000011) runs in 3 cycles. Step 3 has `pc_we`, `pc_src`=10, `rf_we`, `reg_dst`=10 (register 31) and `wb_src`=10 (PC), and is followed by fetch.
- R11: Overflow exception. Applies to a register-format instruction with function 100000 or 100010 that sees `alu_ovf`=1 in step 3. Step 4 is then an exception step instead of write-back. It has `epc_we`, `cause_we`, `cause_val`=1, `pc_we`, `pc_src`=11 (vector 0xC0000000), `alu_a_sel`=0, `alu_b_sel`=01 and `alu_op`=01. Any other function code ignores `alu_ovf`.
- R12: An opcode outside the classes above goes straight from decode to an exception step that matches R11's except `cause_val`=0. Such an instruction takes 3 cycles.
- R13: `rf_we` and `mem_we` are each high for at most one cycle per instruction. Any enable or select that a step does not use is driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| alu_zero | input | 1 | ALU result equals zero |
| alu_ovf | input | 1 | ALU signed overflow |
| pc_we | output | 1 | PC write enable |
| ir_we | output | 1 | Instruction register write enable |
| mdr_we | output | 1 | Memory data register write enable |
| ab_we | output | 1 | A/B operand register write enable |
| aluout_we | output | 1 | ALU-out register write enable |
| rf_we | output | 1 | Register file write enable |
| mem_rd | output | 1 | Memory read |
| mem_we | output | 1 | Memory write |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU-out |
| alu_a_sel | output | 1 | ALU first operand: 0 PC, 1 A |
| alu_b_sel | output | 2 | ALU second operand: 00 B, 01 four, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field, 11 opcode-selected |
| pc_src | output | 2 | 00 ALU result, 01 ALU-out, 10 jump target, 11 exception vector |
| reg_dst | output | 2 | 00 bits 20..16, 01 bits 15..11, 10 register 31 |
| wb_src | output | 2 | 00 ALU-out, 01 memory data, 10 PC |
| cause_we | output | 1 | Cause register write enable |
| cause_val | output | 1 | Cause value to record |
| epc_we | output | 1 | Exception-PC register write enable |

## Verification
The bench targets these corner cases:
- An overflow on an unsigned add must be ignored. A controller that trapped on every overflow would branch to the exception step and lose the write-back.
- A branch seen with the zero flag both high and low. If the condition gating were wrong, the PC would be overwritten on a not-taken branch, or kept on a taken one.
- The link step. A mis-steered destination or write-back select would clobber the wrong register or write ALU-out instead of the return address.
- An undefined opcode, where a missing decode default would wander into a datapath step.
- The exact length of every chain. A load that skipped completion or a store that wrote twice would show up as one step out of place.

// File: rtl/mcc_pkg.sv
// Package: shared widths, opcode classes, state codes, select encodings
// and the bundle of control lines driven by the step controller.
// Assumes an instruction layout with a 6-bit opcode and 6-bit function.
package mcc_pkg;

    parameter int OP_W  = 6;
    parameter int FN_W  = 6;
    parameter int SEL_W = 2;

    // opcode values that the decoder recognises
    localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_JMP   = 6'b000010;
    localparam logic [OP_W-1:0] OPC_JAL   = 6'b000011;
    localparam logic [2:0]      OPC_IMM_HI = 3'b001;

    // function codes whose overflow traps
    localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FN_W-1:0] FN_SUB = 6'b100010;

    // select encodings
    localparam logic [SEL_W-1:0] PCS_ALU    = 2'b00;
    localparam logic [SEL_W-1:0] PCS_ALUOUT = 2'b01;
    localparam logic [SEL_W-1:0] PCS_JTGT   = 2'b10;
    localparam logic [SEL_W-1:0] PCS_VEC    = 2'b11;

    localparam logic [SEL_W-1:0] BSEL_REG   = 2'b00;
    localparam logic [SEL_W-1:0] BSEL_FOUR  = 2'b01;
    localparam logic [SEL_W-1:0] BSEL_IMM   = 2'b10;
    localparam logic [SEL_W-1:0] BSEL_IMMSH = 2'b11;

    localparam logic [SEL_W-1:0] AOP_ADD   = 2'b00;
    localparam logic [SEL_W-1:0] AOP_SUB   = 2'b01;
    localparam logic [SEL_W-1:0] AOP_FUNCT = 2'b10;
    localparam logic [SEL_W-1:0] AOP_IMMOP = 2'b11;

    localparam logic [SEL_W-1:0] DST_RT   = 2'b00;
    localparam logic [SEL_W-1:0] DST_RD   = 2'b01;
    localparam logic [SEL_W-1:0] DST_LINK = 2'b10;

    localparam logic [SEL_W-1:0] WB_ALUOUT = 2'b00;
    localparam logic [SEL_W-1:0] WB_MDR    = 2'b01;
    localparam logic [SEL_W-1:0] WB_PC     = 2'b10;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_MADDR, ST_MREAD, ST_LDWB, ST_MWRITE,
        ST_REXEC, ST_RWB, ST_IEXEC, ST_IWB, ST_BRANCH, ST_JUMP,
        ST_LINK, ST_EXC_OVF, ST_EXC_UND
    } state_e;

    typedef enum logic [2:0] {
        CL_RTYPE, CL_LOAD, CL_STORE, CL_IMM, CL_BRANCH, CL_JUMP, CL_LINK, CL_UNDEF
    } opclass_e;

    // control bundle; pc_cond is internal (PC write qualified by zero)
    typedef struct packed {
        logic             pc_we;
        logic             pc_cond;
        logic             ir_we;
        logic             mdr_we;
        logic             ab_we;
        logic             aluout_we;
        logic             rf_we;
        logic             mem_rd;
        logic             mem_we;
        logic             addr_sel;
        logic             alu_a_sel;
        logic [SEL_W-1:0] alu_b_sel;
        logic [SEL_W-1:0] alu_op;
        logic [SEL_W-1:0] pc_src;
        logic [SEL_W-1:0] reg_dst;
        logic [SEL_W-1:0] wb_src;
        logic             cause_we;
        logic             cause_val;
        logic             epc_we;
    } ctrl_t;

endpackage

// File: rtl/mcc_opclass_dec.sv
// Opcode classifier: maps the opcode to an instruction class and flags
// register-format function codes whose signed overflow must trap.
// Assumes opcode/funct are stable from the decode step onward.
module mcc_opclass_dec
    import mcc_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic [FN_W-1:0] funct,
    output opclass_e        op_class,
    output logic            trap_on_ovf
);

    // class lookup; anything unmatched is undefined
    always_comb begin
        if (opcode == OPC_RTYPE)                     op_class = CL_RTYPE;
        else if (opcode == OPC_LOAD)                 op_class = CL_LOAD;
        else if (opcode == OPC_STORE)                op_class = CL_STORE;
        else if (opcode == OPC_BEQ)                  op_class = CL_BRANCH;
        else if (opcode == OPC_JMP)                  op_class = CL_JUMP;
        else if (opcode == OPC_JAL)                  op_class = CL_LINK;
        else if (opcode[OP_W-1 -: 3] == OPC_IMM_HI)  op_class = CL_IMM;
        else                                         op_class = CL_UNDEF;
    end

    // signed add and subtract are the only trapping functions
    always_comb begin
        trap_on_ovf = (funct == FN_ADD) || (funct == FN_SUB);
    end

endmodule

// File: rtl/mcc_next_state.sv
// Next-step logic: the two common steps, then a per-class chain that
// always ends in fetch. Overflow is sampled only in register execute.
module mcc_next_state
    import mcc_pkg::*;
(
    input  state_e   cur,
    input  opclass_e op_class,
    input  logic     trap_on_ovf,
    input  logic     alu_ovf,
    output state_e   nxt
);

    // successor of each step
    always_comb begin
        nxt = ST_FETCH;
        case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                case (op_class)
                    CL_RTYPE:  nxt = ST_REXEC;
                    CL_LOAD:   nxt = ST_MADDR;
                    CL_STORE:  nxt = ST_MADDR;
                    CL_IMM:    nxt = ST_IEXEC;
                    CL_BRANCH: nxt = ST_BRANCH;
                    CL_JUMP:   nxt = ST_JUMP;
                    CL_LINK:   nxt = ST_LINK;
                    default:   nxt = ST_EXC_UND;
                endcase
            end
            ST_MADDR:  nxt = (op_class == CL_LOAD) ? ST_MREAD : ST_MWRITE;
            ST_MREAD:  nxt = ST_LDWB;
            ST_REXEC:  nxt = (alu_ovf && trap_on_ovf) ? ST_EXC_OVF : ST_RWB;
            ST_IEXEC:  nxt = ST_IWB;
            default:   nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcc_out_map.sv
// Moore output map: control bundle for each step. Unused fields stay 0.
// The branch step requests a zero-qualified PC write via pc_cond.
module mcc_out_map
    import mcc_pkg::*;
(
    input  state_e cur,
    output ctrl_t  ctrl
);

    // per-step control values
    always_comb begin
        ctrl = '0;
        case (cur)
            ST_FETCH: begin
                ctrl.pc_we     = 1'b1;
                ctrl.ir_we     = 1'b1;
                ctrl.mem_rd    = 1'b1;
                ctrl.addr_sel  = 1'b0;
                ctrl.alu_a_sel = 1'b0;
                ctrl.alu_b_sel = BSEL_FOUR;
                ctrl.alu_op    = AOP_ADD;
                ctrl.pc_src    = PCS_ALU;
            end
            ST_DECODE: begin
                ctrl.ab_we     = 1'b1;
                ctrl.aluout_we = 1'b1;
                ctrl.alu_b_sel = BSEL_IMMSH;
                ctrl.alu_op    = AOP_ADD;
            end
            ST_MADDR: begin
                ctrl.aluout_we = 1'b1;
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSEL_IMM;
                ctrl.alu_op    = AOP_ADD;
            end
            ST_MREAD: begin
                ctrl.mdr_we   = 1'b1;
                ctrl.mem_rd   = 1'b1;
                ctrl.addr_sel = 1'b1;
            end
            ST_LDWB: begin
                ctrl.rf_we   = 1'b1;
                ctrl.reg_dst = DST_RT;
                ctrl.wb_src  = WB_MDR;
            end
            ST_MWRITE: begin
                ctrl.mem_we   = 1'b1;
                ctrl.addr_sel = 1'b1;
            end
            ST_REXEC: begin
                ctrl.aluout_we = 1'b1;
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSEL_REG;
                ctrl.alu_op    = AOP_FUNCT;
            end
            ST_RWB: begin
                ctrl.rf_we   = 1'b1;
                ctrl.reg_dst = DST_RD;
                ctrl.wb_src  = WB_ALUOUT;
            end
            ST_IEXEC: begin
                ctrl.aluout_we = 1'b1;
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSEL_IMM;
                ctrl.alu_op    = AOP_IMMOP;
            end
            ST_IWB: begin
                ctrl.rf_we   = 1'b1;
                ctrl.reg_dst = DST_RT;
                ctrl.wb_src  = WB_ALUOUT;
            end
            ST_BRANCH: begin
                ctrl.pc_cond   = 1'b1;
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSEL_REG;
                ctrl.alu_op    = AOP_SUB;
                ctrl.pc_src    = PCS_ALUOUT;
            end
            ST_JUMP: begin
                ctrl.pc_we  = 1'b1;
                ctrl.pc_src = PCS_JTGT;
            end
            ST_LINK: begin
                ctrl.pc_we   = 1'b1;
                ctrl.pc_src  = PCS_JTGT;
                ctrl.rf_we   = 1'b1;
                ctrl.reg_dst = DST_LINK;
                ctrl.wb_src  = WB_PC;
            end
            ST_EXC_OVF, ST_EXC_UND: begin
                ctrl.pc_we     = 1'b1;
                ctrl.pc_src    = PCS_VEC;
                ctrl.alu_a_sel = 1'b0;
                ctrl.alu_b_sel = BSEL_FOUR;
                ctrl.alu_op    = AOP_SUB;
                ctrl.epc_we    = 1'b1;
                ctrl.cause_we  = 1'b1;
                ctrl.cause_val = (cur == ST_EXC_OVF);
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/mcc_ctrl_fsm.sv
// Top: multicycle step controller. Holds the step register, combines
// the Moore map with the zero flag for branches, and forces every
// output low while the synchronous active-low reset is applied.
// Assumes the datapath presents opcode/funct from the instruction
// register and the ALU flags of the current cycle.
module mcc_ctrl_fsm
    import mcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  opcode,
    input  logic [FN_W-1:0]  funct,
    input  logic             alu_zero,
    input  logic             alu_ovf,
    output logic             pc_we,
    output logic             ir_we,
    output logic             mdr_we,
    output logic             ab_we,
    output logic             aluout_we,
    output logic             rf_we,
    output logic             mem_rd,
    output logic             mem_we,
    output logic             addr_sel,
    output logic             alu_a_sel,
    output logic [SEL_W-1:0] alu_b_sel,
    output logic [SEL_W-1:0] alu_op,
    output logic [SEL_W-1:0] pc_src,
    output logic [SEL_W-1:0] reg_dst,
    output logic [SEL_W-1:0] wb_src,
    output logic             cause_we,
    output logic             cause_val,
    output logic             epc_we
);

    state_e   state_q;
    state_e   state_d;
    opclass_e op_class;
    logic     trap_on_ovf;
    ctrl_t    ctrl_raw;
    ctrl_t    ctrl_out;

    mcc_opclass_dec u_dec (
        .opcode      (opcode),
        .funct       (funct),
        .op_class    (op_class),
        .trap_on_ovf (trap_on_ovf)
    );

    mcc_next_state u_nxt (
        .cur         (state_q),
        .op_class    (op_class),
        .trap_on_ovf (trap_on_ovf),
        .alu_ovf     (alu_ovf),
        .nxt         (state_d)
    );

    mcc_out_map u_map (
        .cur  (state_q),
        .ctrl (ctrl_raw)
    );

    // step register with synchronous reset to fetch
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // qualify branch PC write by zero flag, silence outputs in reset
    always_comb begin
        ctrl_out = ctrl_raw;
        ctrl_out.pc_we = ctrl_raw.pc_we | (ctrl_raw.pc_cond & alu_zero);
        if (!rst_n) ctrl_out = '0;
    end

    assign pc_we     = ctrl_out.pc_we;
    assign ir_we     = ctrl_out.ir_we;
    assign mdr_we    = ctrl_out.mdr_we;
    assign ab_we     = ctrl_out.ab_we;
    assign aluout_we = ctrl_out.aluout_we;
    assign rf_we     = ctrl_out.rf_we;
    assign mem_rd    = ctrl_out.mem_rd;
    assign mem_we    = ctrl_out.mem_we;
    assign addr_sel  = ctrl_out.addr_sel;
    assign alu_a_sel = ctrl_out.alu_a_sel;
    assign alu_b_sel = ctrl_out.alu_b_sel;
    assign alu_op    = ctrl_out.alu_op;
    assign pc_src    = ctrl_out.pc_src;
    assign reg_dst   = ctrl_out.reg_dst;
    assign wb_src    = ctrl_out.wb_src;
    assign cause_we  = ctrl_out.cause_we;
    assign cause_val = ctrl_out.cause_val;
    assign epc_we    = ctrl_out.epc_we;

    // R13: register write lasts one cycle
    p_single_rfwe_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    // R13: memory write lasts one cycle
    p_single_memwe_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R8: untaken branch leaves PC alone
    p_branch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BRANCH && !alu_zero) |-> !pc_we);

    // R10: link step returns to fetch
    p_link_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LINK) |=> (state_q == ST_FETCH));

    // R11: unsigned functions never reach the overflow trap
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REXEC && !trap_on_ovf) |=> (state_q != ST_EXC_OVF));

    // R11/R12: cause capture comes with EPC save and vectoring
    p_exc_vector_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cause_we |-> (epc_we && pc_we && pc_src == PCS_VEC));

    // R4: load write-back only after memory read step
    p_load_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LDWB) |-> ($past(state_q) == ST_MREAD));

endmodule

// File: tb/mcc_ctrl_fsm_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task queues the expected control vector of
// every step of an instruction; a monitor pops and compares each cycle.
module mcc_ctrl_fsm_tb;

    localparam int S_F = 0, S_D = 1, S_MA = 2, S_MR = 3, S_LW = 4, S_MW = 5,
                   S_RX = 6, S_RW = 7, S_IX = 8, S_IW = 9, S_BR = 10,
                   S_J = 11, S_JL = 12, S_EO = 13, S_EU = 14;

    typedef struct {
        logic [22:0] v;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] opcode = '0;
    logic [5:0] funct = '0;
    logic alu_zero = 1'b0;
    logic alu_ovf = 1'b0;
    logic pc_we, ir_we, mdr_we, ab_we, aluout_we, rf_we, mem_rd, mem_we;
    logic addr_sel, alu_a_sel, cause_we, cause_val, epc_we;
    logic [1:0] alu_b_sel, alu_op, pc_src, reg_dst, wb_src;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    item_t q[$];

    always #2.5 clk = ~clk;

    mcc_ctrl_fsm u_dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct),
        .alu_zero(alu_zero), .alu_ovf(alu_ovf),
        .pc_we(pc_we), .ir_we(ir_we), .mdr_we(mdr_we), .ab_we(ab_we),
        .aluout_we(aluout_we), .rf_we(rf_we), .mem_rd(mem_rd), .mem_we(mem_we),
        .addr_sel(addr_sel), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .alu_op(alu_op), .pc_src(pc_src), .reg_dst(reg_dst), .wb_src(wb_src),
        .cause_we(cause_we), .cause_val(cause_val), .epc_we(epc_we)
    );

    function automatic logic [22:0] observed();
        return {pc_we, ir_we, mdr_we, ab_we, aluout_we, rf_we, mem_rd, mem_we,
                addr_sel, alu_a_sel, alu_b_sel, alu_op, pc_src, reg_dst, wb_src,
                cause_we, cause_val, epc_we};
    endfunction

    // expected vector per step, written from the requirement table
    function automatic logic [22:0] expect_vec(int st, logic z);
        logic pw = 0, iw = 0, mdw = 0, abw = 0, aow = 0, rfw = 0, mr = 0, mw = 0;
        logic ad = 0, as = 0, cw = 0, cv = 0, ew = 0;
        logic [1:0] bs = 0, op = 0, ps = 0, rd = 0, wb = 0;
        case (st)
            S_F:  begin pw = 1; iw = 1; mr = 1; bs = 2'b01; end
            S_D:  begin abw = 1; aow = 1; bs = 2'b11; end
            S_MA: begin aow = 1; as = 1; bs = 2'b10; end
            S_MR: begin mdw = 1; mr = 1; ad = 1; end
            S_LW: begin rfw = 1; wb = 2'b01; end
            S_MW: begin mw = 1; ad = 1; end
            S_RX: begin aow = 1; as = 1; op = 2'b10; end
            S_RW: begin rfw = 1; rd = 2'b01; end
            S_IX: begin aow = 1; as = 1; bs = 2'b10; op = 2'b11; end
            S_IW: begin rfw = 1; end
            S_BR: begin pw = z; as = 1; op = 2'b01; ps = 2'b01; end
            S_J:  begin pw = 1; ps = 2'b10; end
            S_JL: begin pw = 1; ps = 2'b10; rfw = 1; rd = 2'b10; wb = 2'b10; end
            S_EO, S_EU: begin
                pw = 1; ps = 2'b11; bs = 2'b01; op = 2'b01; ew = 1; cw = 1;
                cv = (st == S_EO);
            end
            default: ;
        endcase
        return {pw, iw, mdw, abw, aow, rfw, mr, mw, ad, as, bs, op, ps, rd, wb,
                cw, cv, ew};
    endfunction

    task automatic push(int st, logic z, string tag);
        item_t it;
        it.v = expect_vec(st, z);
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic apply(logic [5:0] op, logic [5:0] fn, logic z, logic ov);
        opcode = op; funct = fn; alu_zero = z; alu_ovf = ov;
    endtask

    task automatic run_cycles(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // monitor: compare one queued step per cycle, away from the edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_cmp++;
                if (observed() !== it.v) begin
                    n_bad++;
                    $display("FAIL %s: got %b expected %b", it.tag, observed(), it.v);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        n_cmp++;
        if (observed() !== 23'd0) begin
            n_bad++;
            $display("FAIL R1: got %b expected %b", observed(), 23'd0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // load (R1 first fetch, R2, R3, R4)
        apply(6'b100011, 6'd0, 1'b1, 1'b1);
        push(S_F, 0, "R1/R2 fetch"); push(S_D, 0, "R3 decode");
        push(S_MA, 0, "R4 addr"); push(S_MR, 0, "R4 read"); push(S_LW, 0, "R4 wb");
        run_cycles(5);
        // store
        apply(6'b101011, 6'd0, 1'b0, 1'b0);
        push(S_F, 0, "R2"); push(S_D, 0, "R3"); push(S_MA, 0, "R5 addr");
        push(S_MW, 0, "R5 write");
        run_cycles(4);
        // signed add, no overflow
        apply(6'b000000, 6'b100000, 1'b0, 1'b0);
        push(S_F, 0, "R2"); push(S_D, 0, "R3"); push(S_RX, 0, "R6 exec");
        push(S_RW, 0, "R6 wb");
        run_cycles(4);
        // unsigned add with overflow: ignored
        apply(6'b000000, 6'b100001, 1'b0, 1'b1);
        push(S_F, 0, "R2"); push(S_D, 0, "R3"); push(S_RX, 0, "R11 exec unsigned");
        push(S_RW, 0, "R11 unsigned no trap");
        run_cycles(4);
        // signed add with overflow
        apply(6'b000000, 6'b100000, 1'b0, 1'b1);
        push(S_F, 0, "R2"); push(S_D, 0, "R3"); push(S_RX, 0, "R11 exec");
        push(S_EO, 0, "R11 trap add");
        run_cycles(4);
        // signed sub with overflow
        apply(6'b000000, 6'b100010, 1'b1, 1'b1);
        push(S_F, 0, "R2"); push(S_D, 0, "R3"); push(S_RX, 0, "R11 exec");
        push(S_EO, 0, "R11 trap sub");
        run_cycles(4);
        // immediate add, overflow flag ignored
        apply(6'b001000, 6'd0, 1'b0, 1'b1);
        push(S_F, 0, "R2"); push(S_D, 0, "R3"); push(S_IX, 0, "R7 exec");
        push(S_IW, 0, "R7 wb");
        run_cycles(4);
        // another immediate opcode
        apply(6'b001111, 6'd0, 1'b0, 1'b0);
        push(S_F, 0, "R2"); push(S_D, 0, "R3"); push(S_IX, 0, "R7 exec 001111");
        push(S_IW, 0, "R7 wb 001111");
        run_cycles(4);
        // branch taken
        apply(6'b000100, 6'd0, 1'b1, 1'b0);
        push(S_F, 0, "R2"); push(S_D, 0, "R3"); push(S_BR, 1, "R8 taken");
        run_cycles(3);
        // branch not taken
        apply(6'b000100, 6'd0, 1'b0, 1'b0);
        push(S_F, 0, "R2"); push(S_D, 0, "R3"); push(S_BR, 0, "R8 not taken");
        run_cycles(3);
        // jump
        apply(6'b000010, 6'd0, 1'b1, 1'b1);
        push(S_F, 0, "R2"); push(S_D, 0, "R3"); push(S_J, 0, "R9 jump");
        run_cycles(3);
        // jump-and-link
        apply(6'b000011, 6'd0, 1'b0, 1'b0);
        push(S_F, 0, "R2"); push(S_D, 0, "R3"); push(S_JL, 0, "R10 link");
        run_cycles(3);
        // undefined opcodes
        apply(6'b111111, 6'd0, 1'b0, 1'b1);
        push(S_F, 0, "R2"); push(S_D, 0, "R3"); push(S_EU, 0, "R12 undefined 111111");
        run_cycles(3);
        apply(6'b010000, 6'b100000, 1'b1, 1'b1);
        push(S_F, 0, "R2"); push(S_D, 0, "R3"); push(S_EU, 0, "R12 undefined 010000");
        run_cycles(3);
        // back to fetch after exception, then reset in mid-chain (R1)
        apply(6'b100011, 6'd0, 1'b0, 1'b0);
        push(S_F, 0, "R12 return to fetch"); push(S_D, 0, "R3");
        push(S_MA, 0, "R4 addr");
        run_cycles(3);
        rst_n = 1'b0;
        push(23'd0 == 23'd0 ? S_F : S_F, 0, "R1 placeholder");
        void'(q.pop_back());
        #2;
        n_cmp++;
        if (observed() !== 23'd0) begin
            n_bad++;
            $display("FAIL R1 reset mid-load: got %b expected %b", observed(), 23'd0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        push(S_F, 0, "R1 fetch after reset"); push(S_D, 0, "R3");
        push(S_MA, 0, "R4 addr"); push(S_MR, 0, "R4 read"); push(S_LW, 0, "R4 wb");
        run_cycles(5);
        push(S_F, 0, "R13 next fetch");
        run_cycles(1);
        #2;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R13: got %0d pending expected 0", q.size());
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule